// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Engine

This block turns simple bus reads into single-bit serial flash read transactions. The bus address is split into two parts. The upper bits pick one of several chip-select windows and the lower bits give the byte offset inside that window. When a read is accepted, the engine runs one serial transaction on the selected device and then returns the data:

1. It selects the device.
2. It sends the read opcode and the address.
3. For a fast read, it sends filler dummy bytes.
4. It shifts in one or four data bytes.

Each chip select has its own 32-bit control word. Software writes this word through a small write port. It sets the command mode, the opcode, the dummy-byte count, per-device 4-byte addressing, the idle clock level and the bit order. A separate enable vector can also turn on 4-byte addressing for each chip select. The engine decodes the selected control word when it accepts a request. Later writes therefore never disturb a transaction that is already running.

Top module: `sfl_read_engine`

## Requirements
- R1: After reset every `cs_n` bit is high, `sck` is low and `req_ready` is low. Every control word starts in normal-read mode with opcode 0x03 and 3-byte addressing, so a read issued with no configuration sends 0x03 and three address bytes.
- R2: Control word bits 1:0 select the command mode: 0 is normal read, 1 is fast read, 2 is write, 3 is user. The opcode in bits 23:16 is the first byte sent.
- R3: With 3-byte addressing the opcode is followed by address bits 23:16, then 15:8, then 7:0.
- R4: 4-byte addressing is used when bit n of `wide_wdata` (as last written) is set for chip select n, or when control bit 13 is set. The opcode is then followed by four address bytes, most significant first, taken from the zero-extended window offset.
- R5: A fast read sends as many 0xFF dummy bytes as the 3-bit count {bit 14, bits 7:6}. A normal read sends none, whatever those bits hold.
- R6: `req_quad`=0 returns one data byte and `req_quad`=1 returns four. The first byte received lands in `req_rdata[7:0]`, and lanes that were not requested read as zero.
- R7: By default each byte is sent and received most significant bit first. Control bit 5 selects least significant bit first, for both MOSI and MISO.
- R8: One SCK period lasts SCK_DIV clocks. MOSI changes only on a falling SCK edge while a device is selected, and MISO is sampled on the rising edge. Control bit 4 sets the idle SCK level high (mode 3), otherwise it is low (mode 0). This level is set before chip select falls. The transaction sends exactly 8×(1 + address bytes + dummy bytes + data bytes) rising edges.
- R9: The request address bits above WIN_LOG2 select the chip select. Only that `cs_n` bit goes low, and at most one bit is ever low.
- R10: `req_ready` is a one-cycle pulse, raised on the same edge that returns `cs_n` high. `req_rdata` is valid while `req_ready` is high.
- R11: A request whose selected word is in mode 2 or 3, or whose chip-select field is NUM_CS or above, produces no serial activity. It is answered with `req_ready` and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | CSW | Chip select whose control word is written |
| cfg_wdata | input | 32 | New control word |
| wide_we | input | 1 | Write strobe for the 4-byte enable vector |
| wide_wdata | input | NUM_CS | 4-byte addressing enable, one bit per chip select |
| req_valid | input | 1 | Read request, held until `req_ready` |
| req_addr | input | CSW+WIN_LOG2 | Chip-select field and byte offset |
| req_quad | input | 1 | 1: four bytes, 0: one byte |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, byte 0 in the low lane |
| sck | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest situation to reach from the ports is the longest frame: 4-byte addressing, seven dummy bytes, least-significant-bit-first order and an idle-high clock, all in one transaction. Here the split dummy field, the address-length selection and the bit-order reversal all meet at the boundary between the header and the data. The stimulus table reaches this case by programming a control word that sets every one of those bits. A behavioural flash on the serial pins parses the address from the bits it sees and answers with data computed from that address. Other table rows set the dummy bits in normal-read mode, set the 4-byte enable from each of its two sources, and end at a window offset near the top of the window.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

   typedef enum logic [1:0] {
      CMD_PLAIN  = 2'd0,
      CMD_FAST   = 2'd1,
      CMD_PROG   = 2'd2,
      CMD_MANUAL = 2'd3
   } cmd_mode_e;

   // control word after reset: plain read, opcode 0x03, 3-byte address
   localparam logic [31:0] CTL_RESET = 32'h0003_0000;

   // longest frame: opcode + 4 address + 7 dummy + 4 data bytes
   localparam int MAX_FRAME_BYTES = 16;

   typedef struct packed {
      logic [7:0] opcode;
      logic       wide;
      logic [2:0] dummy;
      logic       lsb;
      logic       cpol;
   } frame_t;

endpackage

// File: rtl/sfl_cfg_bank.sv
module sfl_cfg_bank #(
   parameter int NUM_CS = 3,
   parameter int CSW    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CSW-1:0]       cfg_idx,
   input  logic [31:0]          cfg_wdata,
   input  logic                 wide_we,
   input  logic [NUM_CS-1:0]    wide_wdata,
   output logic [NUM_CS*32-1:0] ctl_flat,
   output logic [NUM_CS-1:0]    wide_q
);
   import sfl_pkg::*;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= CTL_RESET;
         else if (cfg_we && cfg_idx == CSW'(g))
            word_q <= cfg_wdata;
      end
      assign ctl_flat[g*32 +: 32] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wide_q <= '0;
      else if (wide_we)
         wide_q <= wide_wdata;
   end

endmodule

// File: rtl/sfl_frame_dec.sv
module sfl_frame_dec #(
   parameter int NUM_CS = 3,
   parameter int CSW    = 2
) (
   input  logic [NUM_CS*32-1:0] ctl_flat,
   input  logic [NUM_CS-1:0]    wide_q,
   input  logic [CSW-1:0]       sel,
   output sfl_pkg::frame_t      frame,
   output logic                 serve
);
   import sfl_pkg::*;

   logic [31:0] word;
   logic        wide_bit;
   logic        in_range;
   cmd_mode_e   mode;

   always_comb begin
      word     = CTL_RESET;
      wide_bit = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (sel == CSW'(i)) begin
            word     = ctl_flat[i*32 +: 32];
            wide_bit = wide_q[i];
         end
      end
      in_range     = int'(sel) < NUM_CS;
      mode         = cmd_mode_e'(word[1:0]);
      serve        = in_range && (mode == CMD_PLAIN || mode == CMD_FAST);
      frame.opcode = word[23:16];
      frame.wide   = wide_bit | word[13];
      // the dummy count is split: its top bit sits apart from the other two
      frame.dummy  = (mode == CMD_FAST) ? {word[14], word[7:6]} : 3'd0;
      frame.lsb    = word[5];
      frame.cpol   = word[4];
   end

endmodule

// File: rtl/sfl_tx_bit.sv
module sfl_tx_bit #(
   parameter int BIT_W = 8
) (
   input  sfl_pkg::frame_t  frame,
   input  logic [31:0]      addr,
   input  logic [BIT_W-1:0] bit_idx,
   output logic             mosi_bit
);
   int         byte_no;
   int         alen;
   logic [7:0] val;
   logic [2:0] pos;

   always_comb begin
      byte_no = int'(bit_idx) / 8;
      alen    = frame.wide ? 4 : 3;
      if (byte_no == 0)
         val = frame.opcode;
      else if (byte_no <= alen)
         val = 8'(addr >> (8 * (alen - byte_no)));
      else
         val = 8'hFF;
      pos      = 3'(bit_idx);
      mosi_bit = frame.lsb ? val[pos] : val[3'd7 - pos];
   end

endmodule

// File: rtl/sfl_read_engine.sv
module sfl_read_engine #(
   parameter int NUM_CS   = 3,
   parameter int WIN_LOG2 = 26,
   parameter int SCK_DIV  = 4,
   localparam int CSW     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int REQ_AW  = CSW + WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CSW-1:0]    cfg_idx,
   input  logic [31:0]       cfg_wdata,
   input  logic              wide_we,
   input  logic [NUM_CS-1:0] wide_wdata,
   input  logic              req_valid,
   input  logic [REQ_AW-1:0] req_addr,
   input  logic              req_quad,
   output logic              req_ready,
   output logic [31:0]       req_rdata,
   output logic              sck,
   output logic [NUM_CS-1:0] cs_n,
   output logic              mosi,
   input  logic              miso
);
   import sfl_pkg::*;

   localparam int HALF     = SCK_DIV / 2;
   localparam int DIV_W    = $clog2(SCK_DIV);
   localparam int MAX_BITS = 8 * MAX_FRAME_BYTES;
   localparam int BIT_W    = $clog2(MAX_BITS + 1);

   if (SCK_DIV < 4 || (SCK_DIV % 2) != 0) begin : g_bad_div
      $error("SCK_DIV must be even and at least 4");
   end
   if (WIN_LOG2 < 8 || WIN_LOG2 > 32) begin : g_bad_win
      $error("WIN_LOG2 must lie in 8..32");
   end
   if (NUM_CS < 1) begin : g_bad_cs
      $error("NUM_CS must be at least 1");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_SHIFT} st_e;

   logic [NUM_CS*32-1:0] ctl_flat;
   logic [NUM_CS-1:0]    wide_q;
   frame_t               fr_live, fr_q;
   logic                 serve_live;
   logic [CSW-1:0]       sel_in, sel_q;
   logic [31:0]          addr_q;
   st_e                  st_q;
   logic [DIV_W-1:0]     div_q;
   logic [BIT_W-1:0]     bit_q, data_start_q, last_bit_q;
   logic [BIT_W-1:0]     ds_live, last_live, tx_idx, d_off;
   logic [4:0]           rd_idx;
   logic                 mosi_nxt;
   logic                 ready_q, sck_q, mosi_q;
   logic [NUM_CS-1:0]    cs_n_q;
   logic [31:0]          rdata_q;

   sfl_cfg_bank #(.NUM_CS(NUM_CS), .CSW(CSW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .wide_we(wide_we), .wide_wdata(wide_wdata),
      .ctl_flat(ctl_flat), .wide_q(wide_q)
   );

   assign sel_in = req_addr[REQ_AW-1 -: CSW];

   sfl_frame_dec #(.NUM_CS(NUM_CS), .CSW(CSW)) u_dec (
      .ctl_flat(ctl_flat), .wide_q(wide_q), .sel(sel_in),
      .frame(fr_live), .serve(serve_live)
   );

   always_comb begin
      ds_live   = BIT_W'(8 * (1 + (fr_live.wide ? 4 : 3) + int'(fr_live.dummy)));
      last_live = ds_live + BIT_W'(req_quad ? 31 : 7);
      tx_idx    = (st_q == ST_PREP) ? '0 : bit_q + BIT_W'(1);
      d_off     = bit_q - data_start_q;
      // MSB-first order is the low three index bits reversed: 7-x == x^7
      rd_idx    = 5'(d_off) ^ {2'b00, {3{~fr_q.lsb}}};
   end

   sfl_tx_bit #(.BIT_W(BIT_W)) u_tx (
      .frame(fr_q), .addr(addr_q), .bit_idx(tx_idx), .mosi_bit(mosi_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         fr_q         <= '0;
         sel_q        <= '0;
         addr_q       <= '0;
         div_q        <= '0;
         bit_q        <= '0;
         data_start_q <= '0;
         last_bit_q   <= '0;
         ready_q      <= 1'b0;
         sck_q        <= 1'b0;
         mosi_q       <= 1'b0;
         cs_n_q       <= '1;
         rdata_q      <= '0;
      end else begin
         ready_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid && !ready_q) begin
                  rdata_q <= '0;
                  if (serve_live) begin
                     fr_q         <= fr_live;
                     sel_q        <= sel_in;
                     addr_q       <= 32'(req_addr[WIN_LOG2-1:0]);
                     data_start_q <= ds_live;
                     last_bit_q   <= last_live;
                     sck_q        <= fr_live.cpol;
                     st_q         <= ST_PREP;
                  end else begin
                     ready_q <= 1'b1;
                  end
               end
            end
            ST_PREP: begin
               cs_n_q <= ~(NUM_CS'(1) << sel_q);
               mosi_q <= mosi_nxt;
               div_q  <= '0;
               bit_q  <= '0;
               st_q   <= ST_SHIFT;
            end
            ST_SHIFT: begin
               div_q <= (int'(div_q) == SCK_DIV - 1) ? '0 : div_q + DIV_W'(1);
               if (int'(div_q) == HALF - 1) begin
                  sck_q <= 1'b1;
                  if (bit_q >= data_start_q)
                     rdata_q[rd_idx] <= miso;
               end else if (int'(div_q) == SCK_DIV - 1) begin
                  if (bit_q == last_bit_q) begin
                     cs_n_q  <= '1;
                     sck_q   <= fr_q.cpol;
                     ready_q <= 1'b1;
                     st_q    <= ST_IDLE;
                  end else begin
                     sck_q  <= 1'b0;
                     mosi_q <= mosi_nxt;
                     bit_q  <= bit_q + BIT_W'(1);
                  end
               end else begin
                  sck_q <= (int'(div_q) + 1 >= HALF);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = ready_q;
   assign req_rdata = rdata_q;
   assign sck       = sck_q;
   assign cs_n      = cs_n_q;
   assign mosi      = mosi_q;

endmodule

// File: rtl/sfl_read_engine_chk.sv
module sfl_read_engine_chk #(
   parameter int NUM_CS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CS-1:0] cs_n,
   input logic              sck,
   input logic              mosi,
   input logic              req_ready
);

   // R9
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);

   // R10
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R10
   ready_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&cs_n));

   // R10
   release_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&$past(cs_n)) && (&cs_n)) |-> req_ready);

   // R8
   mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&cs_n) && !(&$past(cs_n)) && (mosi != $past(mosi))) |-> ($past(sck) && !sck));

endmodule

bind sfl_read_engine sfl_read_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
   .req_ready(req_ready)
);

// File: tb/sfl_read_engine_bench.sv
`timescale 1ns/1ps
module sfl_read_engine_bench;

   localparam int NUM_CS   = 3;
   localparam int WIN_LOG2 = 26;
   localparam int SCK_DIV  = 4;
   localparam int REQ_AW   = 28;

   typedef struct packed {
      logic [1:0]  cs;
      logic [31:0] ctl;
      logic [2:0]  wide;
      logic [25:0] ofs;
      logic        quad;
   } vec_t;

   // R2 R3 R4 R5 R6 R7 R8 R11 exercised by these rows
   localparam vec_t VECS [10] = '{
      '{2'd0, 32'h0003_0000, 3'b000, 26'h012_3456, 1'b1},
      '{2'd1, 32'h000B_0041, 3'b000, 26'h0AB_CDEF, 1'b0},
      '{2'd2, 32'h000B_4041, 3'b100, 26'h3FF_FFFC, 1'b1},
      '{2'd0, 32'h0013_2000, 3'b000, 26'h200_0010, 1'b1},
      '{2'd1, 32'h0003_40C0, 3'b000, 26'h000_0000, 1'b1},
      '{2'd1, 32'h0003_0020, 3'b000, 26'h0C3_5A11, 1'b1},
      '{2'd2, 32'h000B_0011, 3'b000, 26'h001_0203, 1'b0},
      '{2'd0, 32'h0003_0002, 3'b000, 26'h000_1234, 1'b1},
      '{2'd0, 32'h0003_0003, 3'b000, 26'h000_1234, 1'b1},
      '{2'd1, 32'h000B_60F1, 3'b000, 26'h1A2_B3C4, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_idx = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              wide_we = 1'b0;
   logic [NUM_CS-1:0] wide_wdata = '0;
   logic              req_valid = 1'b0;
   logic [REQ_AW-1:0] req_addr = '0;
   logic              req_quad = 1'b0;
   logic              req_ready;
   logic [31:0]       req_rdata;
   logic              sck;
   logic [NUM_CS-1:0] cs_n;
   logic              mosi;
   logic              miso = 1'b0;

   sfl_read_engine #(.NUM_CS(NUM_CS), .WIN_LOG2(WIN_LOG2), .SCK_DIV(SCK_DIV)) u_sfl_read_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .wide_we(wide_we), .wide_wdata(wide_wdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_quad(req_quad),
      .req_ready(req_ready), .req_rdata(req_rdata), .sck(sck), .cs_n(cs_n),
      .mosi(mosi), .miso(miso)
   );

   int n_checks = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural flash ----------------
   logic       sel_any;
   assign sel_any = ~&cs_n;

   int          rises = 0;
   int          sel_events = 0;
   logic [7:0]  rxb [16];
   logic        m_lsb = 1'b0;
   int          m_alen = 3;
   int          m_hdr = 4;
   logic [31:0] m_addr = '0;
   logic        sck_at_sel = 1'b0;
   logic [2:0]  cs_at_sel = '0;
   realtime     t_r0 = 0.0;
   realtime     t_r1 = 0.0;

   function automatic logic [7:0] mem_at(input logic [31:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic logic miso_bit(input int idx);
      int b;
      logic [7:0] v;
      b = idx / 8;
      if (b < m_hdr) return 1'b0;
      v = mem_at(m_addr + 32'(b - m_hdr));
      return m_lsb ? v[idx % 8] : v[7 - (idx % 8)];
   endfunction

   always @(posedge sel_any) begin
      rises = 0;
      sel_events++;
      sck_at_sel = sck;
      cs_at_sel = ~cs_n;
      for (int i = 0; i < 16; i++) rxb[i] = 8'h00;
      miso = miso_bit(0);
   end

   always @(posedge sck) begin
      if (sel_any) begin
         int idx;
         int pos;
         idx = rises;
         pos = m_lsb ? (idx % 8) : (7 - (idx % 8));
         if (idx / 8 < 16) rxb[idx / 8][pos] = mosi;
         if (idx == 0) t_r0 = $realtime;
         if (idx == 1) t_r1 = $realtime;
         rises++;
         if (rises == 8 * (1 + m_alen)) begin
            m_addr = '0;
            for (int i = 1; i <= m_alen; i++) m_addr = (m_addr << 8) | 32'(rxb[i]);
         end
      end
   end

   always @(negedge sck) begin
      if (sel_any) miso = miso_bit(rises);
   end

   // ---------------- driving tasks ----------------
   task automatic cfg_write(input logic [1:0] idx, input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wide_write(input logic [2:0] w);
      @(negedge clk);
      wide_we = 1'b1; wide_wdata = w;
      @(negedge clk);
      wide_we = 1'b0;
   endtask

   task automatic run_req(input logic [1:0] cs, input logic [25:0] ofs, input logic quad,
                          output logic [31:0] data, output logic [2:0] cs_at_rdy,
                          output logic rdy_after);
      int lat;
      @(negedge clk);
      req_addr = {cs, ofs}; req_quad = quad; req_valid = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!req_ready && lat < 5000);
      data = req_rdata;
      cs_at_rdy = cs_n;
      req_valid = 1'b0;
      @(negedge clk);
      rdy_after = req_ready;
   endtask

   task automatic do_vector(input vec_t v, input int row);
      logic [1:0]  mode;
      bit          serve;
      int          alen, dum, nd, prev_sel;
      logic [31:0] addr, exp_data, act_a, exp_a, data;
      logic [2:0]  rdy_cs;
      logic        rdy_after;
      bit          dum_ok;
      mode  = v.ctl[1:0];
      serve = (mode < 2) && (int'(v.cs) < NUM_CS);
      alen  = (v.wide[v.cs] || v.ctl[13]) ? 4 : 3;
      dum   = (mode == 2'd1) ? int'({v.ctl[14], v.ctl[7:6]}) : 0;
      nd    = v.quad ? 4 : 1;
      addr  = (alen == 4) ? {6'b0, v.ofs} : {8'b0, v.ofs[23:0]};
      exp_data = '0;
      for (int i = 0; i < nd; i++) exp_data[8*i +: 8] = mem_at(addr + 32'(i));
      m_lsb = v.ctl[5]; m_alen = alen; m_hdr = 1 + alen + dum;
      cfg_write(v.cs, v.ctl);
      wide_write(v.wide);
      prev_sel = sel_events;
      run_req(v.cs, v.ofs, v.quad, data, rdy_cs, rdy_after);
      if (serve) begin
         check(sel_events == prev_sel + 1, $sformatf("R9 row %0d single selection", row), 32'(sel_events - prev_sel), 32'd1);
         check(cs_at_sel == (3'b001 << v.cs), $sformatf("R9 row %0d selected line", row), 32'(cs_at_sel), 32'(3'b001 << v.cs));
         check(sck_at_sel == v.ctl[4], $sformatf("R8 row %0d idle level before select", row), 32'(sck_at_sel), 32'(v.ctl[4]));
         check(rxb[0] == v.ctl[23:16], $sformatf("R2 row %0d opcode", row), 32'(rxb[0]), 32'(v.ctl[23:16]));
         act_a = '0;
         for (int i = 1; i <= alen; i++) act_a = (act_a << 8) | 32'(rxb[i]);
         exp_a = addr;
         if (alen == 4)
            check(act_a == exp_a, $sformatf("R4 row %0d address bytes", row), act_a, exp_a);
         else
            check(act_a == exp_a, $sformatf("R3 row %0d address bytes", row), act_a, exp_a);
         dum_ok = 1'b1;
         for (int i = 0; i < dum; i++) if (rxb[1 + alen + i] != 8'hFF) dum_ok = 1'b0;
         check(dum_ok, $sformatf("R5 row %0d dummy bytes 0xFF", row), 32'(dum_ok), 32'd1);
         check(rises == 8 * (1 + alen + dum + nd), $sformatf("R8 R5 row %0d rising edge count", row), 32'(rises), 32'(8 * (1 + alen + dum + nd)));
         check(int'(t_r1 - t_r0) == SCK_DIV * 20, $sformatf("R8 row %0d SCK period ns", row), 32'(int'(t_r1 - t_r0)), 32'(SCK_DIV * 20));
         if (v.ctl[5])
            check(data == exp_data, $sformatf("R7 row %0d LSB-first data", row), data, exp_data);
         else
            check(data == exp_data, $sformatf("R6 row %0d data lanes", row), data, exp_data);
      end else begin
         check(sel_events == prev_sel, $sformatf("R11 row %0d no serial activity", row), 32'(sel_events - prev_sel), 32'd0);
         check(data == 32'd0, $sformatf("R11 row %0d zero data", row), data, 32'd0);
      end
      check(rdy_cs == 3'b111, $sformatf("R10 row %0d deselected at ready", row), 32'(rdy_cs), 32'h7);
      check(rdy_after == 1'b0, $sformatf("R10 row %0d ready single cycle", row), 32'(rdy_after), 32'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] data;
      logic [2:0]  rdy_cs;
      logic        rdy_after;
      int          prev_sel;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(cs_n == 3'b111, "R1 cs_n after reset", 32'(cs_n), 32'h7);
      check(sck == 1'b0, "R1 sck after reset", 32'(sck), 32'd0);
      check(req_ready == 1'b0, "R1 ready during reset", 32'(req_ready), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cs_n == 3'b111 && sck == 1'b0 && req_ready == 1'b0, "R1 idle after reset release",
            {28'd0, cs_n, sck}, 32'he);

      // R1 default control word: plain read 0x03, 3 address bytes, MSB first
      m_lsb = 1'b0; m_alen = 3; m_hdr = 4;
      run_req(2'd2, 26'h00A_BCDE, 1'b0, data, rdy_cs, rdy_after);
      check(rxb[0] == 8'h03, "R1 default opcode", 32'(rxb[0]), 32'h03);
      check(rises == 40, "R1 default frame length", 32'(rises), 32'd40);
      check(data == {24'd0, mem_at(32'h000A_BCDE)}, "R1 default read data", data, {24'd0, mem_at(32'h000A_BCDE)});

      // R11 chip-select field outside NUM_CS
      prev_sel = sel_events;
      run_req(2'd3, 26'h000_0040, 1'b1, data, rdy_cs, rdy_after);
      check(sel_events == prev_sel, "R11 out-of-range select no activity", 32'(sel_events - prev_sel), 32'd0);
      check(data == 32'd0, "R11 out-of-range select zero data", data, 32'd0);
      check(rdy_after == 1'b0, "R10 out-of-range ready single cycle", 32'(rdy_after), 32'd0);

      for (int r = 0; r < 10; r++) do_vector(VECS[r], r);

      // R10 idle after all traffic
      repeat (3) @(negedge clk);
      check(cs_n == 3'b111 && req_ready == 1'b0, "R10 idle at end", {28'd0, cs_n, req_ready}, 32'he);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule